// File: doc/BRIEF.md
# Packed Channel Address and Stack Pointer Register

This block holds two byte-wide registers that software and microcode see as one 16-bit word. The upper byte is the channel address, which selects the I/O task a processor is talking to. The lower byte is the stack pointer. A single combined read port, `rdata`, always shows both registers.

Each register has its own write strobe, and both strobes share one write data word. A channel address write takes its value from the upper byte of that word. A stack pointer write takes its value from the lower byte. The channel address has a second load path, device select. This path decodes a small device code into a one-hot pattern and writes that pattern into the three lowest bits of the channel address. The five bits above are left alone. All strobes are single-cycle control pins. There is no back-pressure: every strobe takes effect at the next rising clock edge. Reset is asynchronous and active low.

Top module: `chan_stack_word`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `rdata` reads 16'h0000.
- R2: `rdata[15:8]` always shows the channel address and `rdata[7:0]` always shows the stack pointer. A write appears on `rdata` in the cycle after the clock edge that samples the strobe.
- R3: When `ca_wr` is high and `dev_sel` is low, the channel address becomes `wdata[15:8]`, and `wdata[7:0]` has no effect on it. Raising the written word by 16'h0100 raises the read-back upper byte by one. All 256 values read back exactly.
- R4: When `sp_wr` is high, the stack pointer becomes `wdata[7:0]`, and `wdata[15:8]` has no effect on it. All 256 values read back exactly.
- R5: When `dev_sel` is high, bits 2:0 of the channel address become a decoded pattern. Code 7 gives 3'b001, code 6 gives 3'b010 and code 5 gives 3'b100. Codes 0 to 4 give 3'b000.
- R6: When `dev_sel` is high and `ca_wr` is low, bits 7:3 of the channel address keep their value. For example, all ones followed by selecting device 7 reads back 8'hF9.
- R7: When `ca_wr` and `dev_sel` are both high in the same cycle, bits 7:3 of the channel address come from `wdata[15:11]` and bits 2:0 come from the device decode.
- R8: A cycle with neither `ca_wr` nor `dev_sel` leaves the channel address unchanged. A cycle without `sp_wr` leaves the stack pointer unchanged.
- R9: The two registers update independently. A stack pointer write never changes the channel address, a channel address write or device select never changes the stack pointer, and strobes to both in the same cycle update both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ca_wr | input | 1 | Load channel address from `wdata[15:8]` |
| sp_wr | input | 1 | Load stack pointer from `wdata[7:0]` |
| wdata | input | 16 | Shared write data word |
| dev_sel | input | 1 | Load decoded device code into channel address bits 2:0 |
| dev_code | input | 3 | Device code for the device-select load |
| rdata | output | 16 | Combined read: {channel address, stack pointer} |

## Verification
The assertions check several properties on every cycle. After a plain bus write, the upper byte is the written upper byte and the lower byte is the written lower byte. After a lone device select, bits 7:3 of the channel address are unchanged. The decoded field is never more than one-hot. Idle cycles leave both bytes stable, and the word is zero after reset. Only the bench scenarios show the exact decoded value for each device code, including the codes that decode to zero. The same applies to the 8'hF9 merge after all ones, the split-source result when a bus write and a device select collide, and the exhaustive 256-value sweeps of both registers.

// File: rtl/chan_stack_pkg.sv
package chan_stack_pkg;
  // Load source chosen for the channel address each cycle
  typedef enum logic [1:0] {
    CA_HOLD  = 2'd0,
    CA_BUS   = 2'd1,
    CA_DEV   = 2'd2,
    CA_MERGE = 2'd3
  } ca_src_e;
endpackage

// File: rtl/chan_dev_decode.sv
module chan_dev_decode #(
  parameter int DEV_W   = 3,
  parameter int FIELD_W = 3
) (
  input  logic [DEV_W-1:0]   dev_code,
  output logic [FIELD_W-1:0] field
);
  localparam int CODE_MAX = (1 << DEV_W) - 1;

  // Bit i of the field is set by the code that sits i steps below the top code
  for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
    assign field[i] = (dev_code == DEV_W'(CODE_MAX - i));
  end
endmodule

// File: rtl/chan_addr_reg.sv
module chan_addr_reg
  import chan_stack_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ca_src_e            src,
  input  logic [BYTE_W-1:0]  bus_byte,
  input  logic [FIELD_W-1:0] dev_field,
  output logic [BYTE_W-1:0]  q
);
  localparam int HI_W = BYTE_W - FIELD_W;

  logic [BYTE_W-1:0] nxt;

  always_comb begin
    unique case (src)
      CA_BUS:   nxt = bus_byte;
      CA_DEV:   nxt = {q[BYTE_W-1 -: HI_W], dev_field};
      CA_MERGE: nxt = {bus_byte[BYTE_W-1 -: HI_W], dev_field};
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/stack_ptr_reg.sv
module stack_ptr_reg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] d,
  output logic [BYTE_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/chan_stack_word.sv
module chan_stack_word
  import chan_stack_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int DEV_W   = 3,
  parameter int FIELD_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ca_wr,
  input  logic                sp_wr,
  input  logic [2*BYTE_W-1:0] wdata,
  input  logic                dev_sel,
  input  logic [DEV_W-1:0]    dev_code,
  output logic [2*BYTE_W-1:0] rdata
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [FIELD_W-1:0] dev_field;
  logic [BYTE_W-1:0]  ca_q;
  logic [BYTE_W-1:0]  sp_q;
  ca_src_e            ca_src;

  always_comb begin
    unique case ({ca_wr, dev_sel})
      2'b10:   ca_src = CA_BUS;
      2'b01:   ca_src = CA_DEV;
      2'b11:   ca_src = CA_MERGE;
      default: ca_src = CA_HOLD;
    endcase
  end

  chan_dev_decode #(.DEV_W(DEV_W), .FIELD_W(FIELD_W)) u_dec (
    .dev_code (dev_code),
    .field    (dev_field)
  );

  chan_addr_reg #(.BYTE_W(BYTE_W), .FIELD_W(FIELD_W)) u_ca (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (ca_src),
    .bus_byte  (wdata[WORD_W-1:BYTE_W]),
    .dev_field (dev_field),
    .q         (ca_q)
  );

  stack_ptr_reg #(.BYTE_W(BYTE_W)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sp_wr),
    .d     (wdata[BYTE_W-1:0]),
    .q     (sp_q)
  );

  assign rdata = {ca_q, sp_q};
endmodule

// File: rtl/chan_stack_word_chk.sv
module chan_stack_word_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ca_wr,
  input logic        sp_wr,
  input logic [15:0] wdata,
  input logic        dev_sel,
  input logic [2:0]  dev_code,
  input logic [15:0] rdata
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> rdata == 16'h0000);

  // R3
  bus_ca_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ca_wr && !dev_sel |=> rdata[15:8] == $past(wdata[15:8]));

  // R4
  bus_sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |=> rdata[7:0] == $past(wdata[7:0]));

  // R5
  dev_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel |=> $onehot0(rdata[10:8]));

  // R6
  dev_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel && !ca_wr |=> rdata[15:11] == $past(rdata[15:11]));

  // R8
  ca_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ca_wr && !dev_sel |=> $stable(rdata[15:8]));

  // R9
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_wr |=> $stable(rdata[7:0]));

  logic unused_ok;
  assign unused_ok = ^dev_code;
endmodule

bind chan_stack_word chan_stack_word_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ca_wr    (ca_wr),
  .sp_wr    (sp_wr),
  .wdata    (wdata),
  .dev_sel  (dev_sel),
  .dev_code (dev_code),
  .rdata    (rdata)
);

// File: tb/tb_chan_stack_word.sv
`timescale 1ns/1ps
module tb_chan_stack_word;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ca_wr = 1'b0;
  logic        sp_wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        dev_sel = 1'b0;
  logic [2:0]  dev_code = '0;
  logic [15:0] rdata;

  int tests = 0;
  int fails = 0;
  logic [7:0] m_ca = '0;
  logic [7:0] m_sp = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chan_stack_word dut (
    .clk(clk), .rst_n(rst_n), .ca_wr(ca_wr), .sp_wr(sp_wr), .wdata(wdata),
    .dev_sel(dev_sel), .dev_code(dev_code), .rdata(rdata)
  );

  function automatic logic [2:0] dec(input logic [2:0] c);
    case (c)
      3'd7:    return 3'b001;
      3'd6:    return 3'b010;
      3'd5:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [7:0] next_ca(input logic [7:0] cur, input logic w, input logic d,
                                         input logic [15:0] wd, input logic [2:0] c);
    logic [7:0] r;
    r = cur;
    if (w) r = wd[15:8];
    if (d) r = {r[7:3], dec(c)};
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    tests++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
    end
  endtask

  // drive one cycle at negedge, let posedge capture, sample at next negedge
  task automatic cyc(input logic w, input logic s, input logic [15:0] wd,
                     input logic d, input logic [2:0] c);
    ca_wr = w; sp_wr = s; wdata = wd; dev_sel = d; dev_code = c;
    @(negedge clk);
    m_ca = next_ca(m_ca, w, d, wd, c);
    if (s) m_sp = wd[7:0];
    ca_wr = 0; sp_wr = 0; dev_sel = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    check("R1", 16'h0000);
    rst_n = 1;
    @(negedge clk);
    check("R1", 16'h0000);

    // R3: all channel address values, noisy low byte, stepping by 16'h0100
    for (int i = 0; i < 256; i++) begin
      cyc(1, 0, {i[7:0], ~i[7:0]}, 0, 0);
      check("R3", {i[7:0], m_sp});
    end
    // R4: all stack pointer values, noisy upper byte; channel address untouched (R9)
    for (int i = 0; i < 256; i++) begin
      cyc(0, 1, {8'hA5 ^ i[7:0], i[7:0]}, 0, 0);
      check("R4", {m_ca, i[7:0]});
    end
    // R5: from zero, codes 5,6,7 give 4,2,1
    cyc(1, 0, 16'h0000, 0, 0);
    cyc(0, 0, 0, 1, 3'd7); check("R5", {8'h01, m_sp});
    cyc(0, 0, 0, 1, 3'd6); check("R5", {8'h02, m_sp});
    cyc(0, 0, 0, 1, 3'd5); check("R5", {8'h04, m_sp});
    // R5: codes 0..4 clear the field
    for (int c = 0; c < 5; c++) begin
      cyc(1, 0, 16'hFF00, 0, 0);
      cyc(0, 0, 16'h1234, 1, c[2:0]);
      check("R5", {8'hF8, m_sp});
    end
    // R6: all ones then device 7 gives F9
    cyc(1, 0, 16'hFFFF, 0, 0);
    cyc(0, 0, 16'h0000, 1, 3'd7); check("R6", {8'hF9, m_sp});
    cyc(0, 0, 16'h0000, 1, 3'd6); check("R6", {8'hFA, m_sp});
    cyc(0, 0, 16'h0000, 1, 3'd5); check("R6", {8'hFC, m_sp});
    // R7: collision, upper from bus, low from decode
    cyc(1, 0, 16'h5700, 1, 3'd6); check("R7", {8'h52, m_sp});
    cyc(1, 0, 16'hAB00, 1, 3'd2); check("R7", {8'hA8, m_sp});
    // R8: idle cycles hold, with noisy data/code
    cyc(0, 0, 16'hFFFF, 0, 3'd7); check("R8", {8'hA8, m_sp});
    // R9: both strobes together
    cyc(1, 1, 16'h3C5A, 0, 0); check("R9", 16'h3C5A);
    check("R2", {m_ca, m_sp});

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] & r[1], r[2] & r[3], r[31:16], r[4] & r[5], r[8:6]);
      check("R2", {m_ca, m_sp});
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule